// File: doc/BRIEF.md
# Protected Key Vault Controller

The controller holds eight 128-bit key areas inside a memory that the bus cannot read. Software sets a global key size, then picks a destination area with a one-hot write. A 32-bit inbound word stream, standing in for the DMA engine, fills the area. When the last expected word lands, the controller marks the area, or the pair of areas for 192-bit and 256-bit keys, as holding a valid key.

A fetch request names an area index. The controller checks the validity bitmap and, when the key is present, copies it word by word into a 256-bit key register that feeds the cipher core. A busy flag stays high during the copy and a one-cycle pulse marks its end. Failed fills and failed fetches set sticky error bits that software clears by writing ones.

Top module: `keyvault_ctrl`

## Requirements
- R1: After reset the valid map (address 2) reads 0, the status (address 4) reads 0, the size code (address 0) reads 0, busy (address 3 bit 31) is 0 and key_out is all zero.
- R2: The size register at address 0 takes code 0 = 128-bit, 1 = 192-bit, 2 = 256-bit, and code 3 acts as 128-bit. Any write to it clears every valid bit, zeroes the key memory and aborts an active fill, even when the value is unchanged.
- R3: A one-hot write to address 1 starts a fill of area n. The fill takes 4, 6 or 8 stream words for 128, 192 or 256 bits. Word j goes to word j of the key, and words 4 to 7 go to area n+1. Valid bit n (and n+1 for a two-area key) is set at the clock edge that takes the final word. Address 1 bit 0 reads 1 while a fill is active.
- R4: A 192-bit key is stored and delivered as 256 bits whose upper 64 bits are zero.
- R5: A write to address 2 clears the valid bit and zeroes the content of every area whose bit is set in the written value.
- R6: Writing an index to address 3 starts a fetch. Busy stays high until the copy ends. Then key_load pulses for one cycle and key_out holds the stored words, with word j at bits 32j+31:32j and the upper half zero for a 128-bit key.
- R7: With a two-area size, a fetch naming either area of a stored pair delivers the whole key, and it needs both areas' valid bits.
- R8: A fetch of an area without a valid key sets status bit 1, leaves busy low and leaves key_out unchanged.
- R9: Status bit 0 is set when kin_last arrives before the final word, when the fill select is not one-hot, or when a two-area key selects area 7. No valid bit is set in any of these cases. Writing ones to address 4 clears the matching status bits.
- R10: Stream words that arrive while no fill is active, and fill selects written during an active fill, are ignored.
- R11: When a fill takes its final word in the same cycle as an invalidate write naming that area, the area ends up invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| kin_valid | input | 1 | Key stream word present |
| kin_data | input | 32 | Key stream word |
| kin_last | input | 1 | Marks the final stream word |
| key_out | output | 256 | Key register towards the cipher core |
| key_load | output | 1 | One-cycle pulse when key_out is complete |

## Verification
A fill taking its final stream word and a bus invalidate of the same area can occur on the same clock edge. The bench drives the last word of a fill into area 6 and a write of 0x40 to the valid map on the same negative edge. It then judges the result by reading a valid map of 0 and a clear status. It also aborts a fill halfway with a size write and confirms that the late words leave the map empty.

// File: rtl/keyvault_pkg.sv
package keyvault_pkg;
    typedef enum logic [1:0] {
        KSZ_128 = 2'd0,
        KSZ_192 = 2'd1,
        KSZ_256 = 2'd2,
        KSZ_ALT = 2'd3
    } ksize_e;

    localparam logic [2:0] RA_SIZE  = 3'd0;
    localparam logic [2:0] RA_FILL  = 3'd1;
    localparam logic [2:0] RA_VALID = 3'd2;
    localparam logic [2:0] RA_FETCH = 3'd3;
    localparam logic [2:0] RA_STAT  = 3'd4;
endpackage

// File: rtl/kv_mem.sv
module kv_mem #(
    parameter int AREAS      = 8,
    parameter int AREA_WORDS = 4,
    parameter int WORD_W     = 32,
    localparam int DEPTH     = AREAS * AREA_WORDS,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AREAS-1:0]  clr_areas,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (clr_areas[i / AREA_WORDS])
                    mem_q[i] <= '0;
                else if (wr_en && (wr_addr == AW'(i)))
                    mem_q[i] <= wr_data;
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

    // R5: a cleared area reads zero on the following cycle
    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_areas[rd_addr / AREA_WORDS]) && $stable(rd_addr) |-> rd_data == '0);
endmodule

// File: rtl/kv_fill.sv
module kv_fill #(
    parameter int AREAS      = 8,
    parameter int AREA_WORDS = 4,
    parameter int WORD_W     = 32,
    localparam int AW        = $clog2(AREAS * AREA_WORDS),
    localparam int IDXW      = $clog2(AREAS),
    localparam int CW        = $clog2(2 * AREA_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDXW-1:0]   start_base,
    input  logic [CW-1:0]     start_nwords,
    input  logic              abort,
    input  logic              kin_valid,
    input  logic [WORD_W-1:0] kin_data,
    input  logic              kin_last,
    output logic              active,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              done,
    output logic              early
);
    typedef struct packed {
        logic            active;
        logic [IDXW-1:0] base;
        logic [CW-1:0]   nwords;
        logic [CW-1:0]   cnt;
    } fill_t;

    fill_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        wr_en = 1'b0;
        done  = 1'b0;
        early = 1'b0;
        if (abort) begin
            s_d.active = 1'b0;
        end else if (s_q.active) begin
            if (kin_valid) begin
                wr_en   = 1'b1;
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == s_q.nwords - 1'b1) begin
                    done       = 1'b1;
                    s_d.active = 1'b0;
                end else if (kin_last) begin
                    early      = 1'b1;
                    s_d.active = 1'b0;
                end
            end
        end else if (start) begin
            s_d.active = 1'b1;
            s_d.base   = start_base;
            s_d.nwords = start_nwords;
            s_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active  = s_q.active;
    assign wr_addr = AW'(s_q.base) * AW'(AREA_WORDS) + AW'(s_q.cnt);
    assign wr_data = kin_data;

    // R3: a fill only ends on a stream word or on an abort
    assert_fill_end_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.active) |-> $past(kin_valid) || $past(abort));
endmodule

// File: rtl/kv_fetch.sv
module kv_fetch #(
    parameter int AREAS      = 8,
    parameter int AREA_WORDS = 4,
    parameter int WORD_W     = 32,
    localparam int AW        = $clog2(AREAS * AREA_WORDS),
    localparam int IDXW      = $clog2(AREAS),
    localparam int CW        = $clog2(2 * AREA_WORDS + 1),
    localparam int KEY_W     = 2 * AREA_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDXW-1:0]   start_base,
    input  logic [CW-1:0]     start_nwords,
    input  logic [WORD_W-1:0] rd_data,
    output logic [AW-1:0]     rd_addr,
    output logic              busy,
    output logic [KEY_W-1:0]  key,
    output logic              load
);
    typedef struct packed {
        logic             busy;
        logic [IDXW-1:0]  base;
        logic [CW-1:0]    nwords;
        logic [CW-1:0]    cnt;
        logic [KEY_W-1:0] key;
        logic             load;
    } fetch_t;

    fetch_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.load = 1'b0;
        if (s_q.busy) begin
            s_d.key[int'(s_q.cnt) * WORD_W +: WORD_W] = rd_data;
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == s_q.nwords - 1'b1) begin
                s_d.busy = 1'b0;
                s_d.load = 1'b1;
            end
        end else if (start) begin
            s_d.busy   = 1'b1;
            s_d.base   = start_base;
            s_d.nwords = start_nwords;
            s_d.cnt    = '0;
            s_d.key    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_addr = AW'(s_q.base) * AW'(AREA_WORDS) + AW'(s_q.cnt);
    assign busy    = s_q.busy;
    assign key     = s_q.key;
    assign load    = s_q.load;

    // R6: the load pulse marks the cycle right after busy drops
    assert_load_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.load |-> !s_q.busy && $past(s_q.busy));
    // R6: the key register does not move outside a copy
    assert_key_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(s_q.busy) && !$past(start) |-> $stable(s_q.key));
endmodule

// File: rtl/keyvault_ctrl.sv
module keyvault_ctrl
    import keyvault_pkg::*;
#(
    parameter int AREAS      = 8,
    parameter int AREA_WORDS = 4,
    parameter int WORD_W     = 32,
    parameter int BUS_W      = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic [2:0]                     bus_addr,
    input  logic [BUS_W-1:0]               bus_wdata,
    output logic [BUS_W-1:0]               bus_rdata,
    input  logic                           kin_valid,
    input  logic [WORD_W-1:0]              kin_data,
    input  logic                           kin_last,
    output logic [2*AREA_WORDS*WORD_W-1:0] key_out,
    output logic                           key_load
);
    localparam int AW   = $clog2(AREAS * AREA_WORDS);
    localparam int IDXW = $clog2(AREAS);
    localparam int CW   = $clog2(2 * AREA_WORDS + 1);

    typedef struct packed {
        logic [1:0]       size;
        logic [AREAS-1:0] valid;
        logic [AREAS-1:0] head;
        logic [AREAS-1:0] fmask;
        logic [AREAS-1:0] fhead;
        logic             wr_err;
        logic             rd_err;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_size, wr_fill, wr_valid, wr_fetch, wr_stat, two_area;
    logic [AREAS-1:0] sel, tmask, wmask, clr_areas;
    logic [IDXW-1:0]  sel_idx, f_idx, f_base, f_next, f_prev;
    logic             fill_ok, fill_start, fill_bad, f_ok, fetch_go, fetch_bad;
    logic [CW-1:0]    fill_nwords, fetch_nwords;
    logic             fill_active, fill_wr, fill_done, fill_early, fetch_busy;
    logic [AW-1:0]    fill_addr, fetch_addr;
    logic [WORD_W-1:0] fill_data, mem_rd;
    logic unused_wdata;

    assign wr_size  = bus_wr && (bus_addr == RA_SIZE);
    assign wr_fill  = bus_wr && (bus_addr == RA_FILL);
    assign wr_valid = bus_wr && (bus_addr == RA_VALID);
    assign wr_fetch = bus_wr && (bus_addr == RA_FETCH);
    assign wr_stat  = bus_wr && (bus_addr == RA_STAT);
    assign two_area = (r_q.size == KSZ_192) || (r_q.size == KSZ_256);
    assign sel      = bus_wdata[AREAS-1:0];
    assign wmask    = bus_wdata[AREAS-1:0];
    assign unused_wdata = ^bus_wdata[BUS_W-1:AREAS];

    always_comb begin
        case (r_q.size)
            KSZ_192: fill_nwords = CW'(3 * AREA_WORDS / 2);
            KSZ_256: fill_nwords = CW'(2 * AREA_WORDS);
            default: fill_nwords = CW'(AREA_WORDS);
        endcase
        fetch_nwords = two_area ? CW'(2 * AREA_WORDS) : CW'(AREA_WORDS);
    end

    // fill select decode
    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < AREAS; i++) if (sel[i]) sel_idx = IDXW'(i);
    end
    assign fill_ok    = $onehot(sel) && !(two_area && sel_idx == IDXW'(AREAS - 1));
    assign fill_start = wr_fill && !fill_active && fill_ok;
    assign fill_bad   = wr_fill && !fill_active && !fill_ok;
    assign tmask      = two_area ? (sel | (sel << 1)) : sel;

    // fetch validity check: a two-area key may be named by either area
    always_comb begin
        f_idx  = bus_wdata[IDXW-1:0];
        f_next = f_idx + 1'b1;
        f_prev = f_idx - 1'b1;
        f_base = f_idx;
        f_ok   = 1'b0;
        if (!two_area) begin
            f_ok = r_q.valid[f_idx];
        end else if (r_q.head[f_idx] && f_idx != IDXW'(AREAS - 1)) begin
            f_ok = r_q.valid[f_idx] && r_q.valid[f_next];
        end else if (f_idx != '0 && r_q.head[f_prev]) begin
            f_base = f_prev;
            f_ok   = r_q.valid[f_prev] && r_q.valid[f_idx];
        end
    end
    assign fetch_go  = wr_fetch && !fetch_busy && f_ok;
    assign fetch_bad = wr_fetch && !fetch_busy && !f_ok;

    assign clr_areas = wr_size ? '1 :
                       ((fill_start ? tmask : '0) | (wr_valid ? wmask : '0));

    always_comb begin
        r_d = r_q;
        if (wr_size) begin
            r_d.size  = bus_wdata[1:0];
            r_d.valid = '0;
            r_d.head  = '0;
        end else begin
            if (fill_start) begin
                r_d.valid = r_d.valid & ~tmask;
                r_d.head  = r_d.head & ~tmask;
                r_d.fmask = tmask;
                r_d.fhead = sel;
            end
            if (fill_done) begin
                r_d.valid = r_d.valid | r_q.fmask;
                r_d.head  = r_d.head | r_q.fhead;
            end
            if (wr_valid) begin
                r_d.valid = r_d.valid & ~wmask;
                r_d.head  = r_d.head & ~wmask;
            end
        end
        if (wr_stat) begin
            r_d.wr_err = r_q.wr_err & ~bus_wdata[0];
            r_d.rd_err = r_q.rd_err & ~bus_wdata[1];
        end
        if (fill_bad || fill_early) r_d.wr_err = 1'b1;
        if (fetch_bad)              r_d.rd_err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_SIZE:  bus_rdata[1:0]       = r_q.size;
            RA_FILL:  bus_rdata[0]         = fill_active;
            RA_VALID: bus_rdata[AREAS-1:0] = r_q.valid;
            RA_FETCH: bus_rdata[BUS_W-1]   = fetch_busy;
            RA_STAT:  bus_rdata[1:0]       = {r_q.rd_err, r_q.wr_err};
            default:  bus_rdata            = '0;
        endcase
    end

    kv_fill #(.AREAS(AREAS), .AREA_WORDS(AREA_WORDS), .WORD_W(WORD_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .start(fill_start), .start_base(sel_idx),
        .start_nwords(fill_nwords), .abort(wr_size), .kin_valid(kin_valid),
        .kin_data(kin_data), .kin_last(kin_last), .active(fill_active),
        .wr_en(fill_wr), .wr_addr(fill_addr), .wr_data(fill_data),
        .done(fill_done), .early(fill_early)
    );

    kv_mem #(.AREAS(AREAS), .AREA_WORDS(AREA_WORDS), .WORD_W(WORD_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(fill_wr), .wr_addr(fill_addr),
        .wr_data(fill_data), .clr_areas(clr_areas), .rd_addr(fetch_addr),
        .rd_data(mem_rd)
    );

    kv_fetch #(.AREAS(AREAS), .AREA_WORDS(AREA_WORDS), .WORD_W(WORD_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .start(fetch_go), .start_base(f_base),
        .start_nwords(fetch_nwords), .rd_data(mem_rd), .rd_addr(fetch_addr),
        .busy(fetch_busy), .key(key_out), .load(key_load)
    );

    // R3: valid bits only appear after a completed fill
    assert_valid_from_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(r_q.valid & ~$past(r_q.valid))) |-> $past(fill_done));
    // R2: a size write leaves no valid key behind
    assert_size_wipes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_size) |-> r_q.valid == '0);
    // R8: a refused fetch never starts a copy
    assert_rderr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_bad |=> !fetch_busy && r_q.rd_err);
    // R9: an early stream end sets no valid bit
    assert_early_novalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_early && !wr_valid && !wr_size |=> r_q.valid == $past(r_q.valid));
endmodule

// File: tb/keyvault_ctrl_tb.sv
module keyvault_ctrl_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         kin_valid = 1'b0;
    logic [31:0]  kin_data = '0;
    logic         kin_last = 1'b0;
    logic [255:0] key_out;
    logic         key_load;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [255:0] exp_q [$];

    always #10 clk = ~clk;

    keyvault_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kin_valid(kin_valid),
        .kin_data(kin_data), .kin_last(kin_last), .key_out(key_out),
        .key_load(key_load)
    );

    function automatic logic [31:0] kword(int seed, int j);
        return 32'hC0DE_0000 + 32'(seed << 8) + 32'(j);
    endfunction

    function automatic logic [255:0] mkkey(int seed, int n);
        logic [255:0] k = '0;
        for (int j = 0; j < n; j++) k[j*32 +: 32] = kword(seed, j);
        return k;
    endfunction

    task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic stream(int seed, int n, int last_at);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            kin_valid = 1'b1; kin_data = kword(seed, j); kin_last = (j == last_at);
        end
        @(negedge clk);
        kin_valid = 1'b0; kin_last = 1'b0;
    endtask

    task automatic expect_reg(string tag, logic [2:0] a, logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        chk(tag, 256'(v), 256'(exp));
    endtask

    // driver side of the scoreboard: queue the key, start the fetch, wait for idle
    task automatic fetch(string tag, int idx, logic [255:0] exp);
        logic [31:0] v;
        bit idle = 0;
        exp_q.push_back(exp);
        bus_write(3'd3, 32'(idx));
        for (int t = 0; t < 20 && !idle; t++) begin
            bus_read(3'd3, v);
            idle = !v[31];
        end
        chk({tag, " busy falls"}, 256'(idle), 256'(1));
        repeat (2) @(negedge clk);
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n && key_load) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected key_load", 256'(1), 256'(0));
            end else begin
                chk("R6 key_out on load", key_out, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_reg("R1 valid map", 3'd2, 32'h0);
        expect_reg("R1 status", 3'd4, 32'h0);
        expect_reg("R1 size", 3'd0, 32'h0);
        expect_reg("R1 busy", 3'd3, 32'h0);
        chk("R1 key_out", key_out, '0);

        // R3 128-bit fill of area 2, then R6 fetch
        bus_write(3'd1, 32'h04);
        expect_reg("R3 fill active", 3'd1, 32'h1);
        stream(1, 4, 3);
        expect_reg("R3 valid map", 3'd2, 32'h04);
        fetch("R6 fetch area 2", 2, mkkey(1, 4));
        chk("R6 key_out held", key_out, mkkey(1, 4));

        // R10 stray stream words
        stream(9, 4, 3);
        expect_reg("R10 map after stray words", 3'd2, 32'h04);
        expect_reg("R10 status after stray words", 3'd4, 32'h0);

        // R8 fetch of empty area
        bus_write(3'd3, 32'd5);
        expect_reg("R8 busy stays low", 3'd3, 32'h0);
        expect_reg("R8 read error", 3'd4, 32'h2);
        chk("R8 key_out unchanged", key_out, mkkey(1, 4));
        bus_write(3'd4, 32'h3);
        expect_reg("R9 status cleared", 3'd4, 32'h0);

        // R9 early end and bad select
        bus_write(3'd1, 32'h08);
        stream(2, 3, 2);
        expect_reg("R9 early end error", 3'd4, 32'h1);
        expect_reg("R9 map after early end", 3'd2, 32'h04);
        bus_write(3'd4, 32'h1);
        bus_write(3'd1, 32'h06);
        expect_reg("R9 non-one-hot error", 3'd4, 32'h1);
        expect_reg("R9 no fill started", 3'd1, 32'h0);
        bus_write(3'd4, 32'h1);

        // R10 select during active fill ignored
        bus_write(3'd1, 32'h01);
        bus_write(3'd1, 32'h02);
        stream(3, 4, 3);
        expect_reg("R10 second select ignored", 3'd2, 32'h05);

        // R5 invalidate
        bus_write(3'd2, 32'h05);
        expect_reg("R5 map after invalidate", 3'd2, 32'h0);
        bus_write(3'd3, 32'd2);
        expect_reg("R5 fetch after invalidate", 3'd4, 32'h2);
        bus_write(3'd4, 32'h3);

        // R2 same-value size write wipes, and aborts a fill
        bus_write(3'd1, 32'h02);
        stream(4, 4, 3);
        bus_write(3'd0, 32'h0);
        expect_reg("R2 map wiped", 3'd2, 32'h0);
        bus_write(3'd1, 32'h40);
        stream(5, 2, -1);
        bus_write(3'd0, 32'h0);
        expect_reg("R2 fill aborted", 3'd1, 32'h0);
        stream(5, 2, 1);
        expect_reg("R2 late words ignored", 3'd2, 32'h0);
        expect_reg("R2 no error on abort", 3'd4, 32'h0);

        // R3 / R7 256-bit key in areas 4 and 5
        bus_write(3'd0, 32'h2);
        expect_reg("R2 size code", 3'd0, 32'h2);
        bus_write(3'd1, 32'h10);
        stream(6, 8, 7);
        expect_reg("R3 pair valid", 3'd2, 32'h30);
        fetch("R7 fetch upper area", 5, mkkey(6, 8));
        fetch("R7 fetch lower area", 4, mkkey(6, 8));
        bus_write(3'd2, 32'h20);
        bus_write(3'd3, 32'd4);
        expect_reg("R7 half pair refused", 3'd4, 32'h2);
        bus_write(3'd4, 32'h3);

        // R9 two-area key in area 7
        bus_write(3'd1, 32'h80);
        expect_reg("R9 area 7 pair error", 3'd4, 32'h1);
        expect_reg("R9 map unchanged", 3'd2, 32'h10);
        bus_write(3'd4, 32'h1);

        // R4 192-bit key
        bus_write(3'd0, 32'h1);
        expect_reg("R2 map wiped on size change", 3'd2, 32'h0);
        bus_write(3'd1, 32'h01);
        stream(7, 6, 5);
        expect_reg("R4 pair valid", 3'd2, 32'h03);
        fetch("R4 upper 64 bits zero", 1, mkkey(7, 6));

        // R11 final word and invalidate in the same cycle
        bus_write(3'd0, 32'h0);
        bus_write(3'd1, 32'h40);
        stream(8, 3, -1);
        @(negedge clk);
        kin_valid = 1'b1; kin_data = kword(8, 3); kin_last = 1'b1;
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h40;
        @(negedge clk);
        kin_valid = 1'b0; kin_last = 1'b0; bus_wr = 1'b0;
        expect_reg("R11 invalidate wins", 3'd2, 32'h0);
        expect_reg("R11 no error", 3'd4, 32'h0);
        expect_reg("R11 fill ended", 3'd1, 32'h0);

        repeat (4) @(negedge clk);
        chk("R6 scoreboard drained", 256'(exp_q.size()), 256'(0));
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule